// File: doc/BRIEF.md
# Double-Buffered Scanout Address Generator

This block turns per-screen framebuffer settings into the stream of byte addresses that a display refresh engine reads, one address per pixel, in raster order: left to right within a row, rows top to bottom. It stores settings for two independent screens. Each screen has a size word, a pixel format code, a row pitch in bytes, four base addresses and a buffer-select bit. The four base addresses form two sets, each with a left-eye base and a right-eye base.

A frame begins with a one-cycle frame-start pulse that names the screen and the eye. At that edge the block captures the chosen base address, the frame size, the pitch and the byte count per pixel. It then presents addresses through a valid/ready handshake and flags the final pixel of the frame. Settings can be rewritten at any time. The running frame keeps its captured copy, so a page flip only takes effect at the next frame boundary.

Top module: `scan_addr_gen`

## Requirements
- R1: After reset, `addr_valid`, `addr_last` and `fmt_err` are 0, and every setting register of both screens is 0.
- R2: A setting write uses `cfg_reg` to pick the register: 0 is size, 1 is format, 2 is pitch, 3 is left base of set 0, 4 is left base of set 1, 5 is right base of set 0, 6 is right base of set 1, and 7 is buffer select (bit 0). In the size word, bits 15:0 hold the width in pixels and bits 31:16 hold the height in rows. An accepted frame presents exactly width × height addresses, and `addr_valid` is 0 in the cycle after the last one is taken.
- R3: The format code is bits 2:0 of register 1. Code 0 steps 4 bytes per pixel, code 1 steps 3 bytes, and codes 2, 3 and 4 step 2 bytes.
- R4: The address for pixel (row r, column c) is base + r × pitch + c × bytes-per-pixel, modulo 2^32. Pixels are presented in raster order.
- R5: Buffer select 0 uses set 0 and buffer select 1 uses set 1. `frame_right` = 1 picks the right-eye base of that set, and `frame_right` = 0 picks the left-eye base.
- R6: Base addresses, buffer select, size, format and pitch are captured at the accepted frame start. A write made during a frame, including one in the same cycle as the frame start, affects only later frames.
- R7: While `addr_valid` is 1 and `pix_ready` is 0, the address and `addr_valid` hold unchanged into the next cycle.
- R8: A frame start that arrives while a frame is in progress is ignored. No second frame follows.
- R9: A frame start on a screen whose width or height is 0 produces no addresses.
- R10: Format codes 5, 6 and 7 step 4 bytes per pixel. A frame start accepted with such a code sets `fmt_err`, which then stays 1 until reset.
- R11: The settings of one screen are unaffected by writes addressed to the other screen.
- R12: `addr_last` is 1 exactly while the final pixel of the frame is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_screen | input | 1 | Screen addressed by the write |
| cfg_reg | input | 3 | Register addressed by the write |
| cfg_wdata | input | 32 | Write data |
| frame_start | input | 1 | One-cycle frame start pulse |
| frame_screen | input | 1 | Screen to scan out |
| frame_right | input | 1 | 1 selects the right-eye base |
| pix_ready | input | 1 | Consumer takes the current address |
| addr_valid | output | 1 | An address is presented |
| addr | output | 32 | Byte address of the current pixel |
| addr_last | output | 1 | Current address is the frame's final pixel |
| fmt_err | output | 1 | Sticky flag for an illegal format code |

## Verification
Two functions can fall in the same clock edge: a setting write and the capture of a frame start. The bench provokes this by raising a base-address write in the very cycle of the frame start, and also by writing the active base while a frame is running. It judges the outcome by checking that the running frame's addresses come from the old base and that the following frame starts at the new one. A second overlap is a frame start arriving while a frame is active. The bench checks that the frame still ends after exactly width × height addresses and that nothing follows.

// File: rtl/scan_pkg.sv
package scan_pkg;

    // Register word layout shared by the setting interface
    localparam int WORD_W = 32;
    localparam int DIM_W  = 16;
    localparam int FMT_W  = 3;
    localparam int REG_W  = 3;
    localparam int BPP_W  = 3;
    localparam int NUM_BASES = 4;

    typedef enum logic [REG_W-1:0] {
        REG_SIZE   = 3'd0,
        REG_FMT    = 3'd1,
        REG_PITCH  = 3'd2,
        REG_LEFT0  = 3'd3,
        REG_LEFT1  = 3'd4,
        REG_RIGHT0 = 3'd5,
        REG_RIGHT1 = 3'd6,
        REG_BUFSEL = 3'd7
    } cfg_reg_e;

    localparam logic [FMT_W-1:0] FMT_RGBA8  = 3'd0;
    localparam logic [FMT_W-1:0] FMT_RGB8   = 3'd1;
    localparam logic [FMT_W-1:0] FMT_RGB565 = 3'd2;
    localparam logic [FMT_W-1:0] FMT_RGB5A1 = 3'd3;
    localparam logic [FMT_W-1:0] FMT_RGBA4  = 3'd4;

    // Byte step per pixel; undefined codes fall back to the widest step
    function automatic logic [BPP_W-1:0] fmt_bpp(input logic [FMT_W-1:0] code);
        logic [BPP_W-1:0] step;
        case (code)
            FMT_RGBA8:  step = 3'd4;
            FMT_RGB8:   step = 3'd3;
            FMT_RGB565,
            FMT_RGB5A1,
            FMT_RGBA4:  step = 3'd2;
            default:    step = 3'd4;
        endcase
        return step;
    endfunction

    function automatic logic fmt_bad(input logic [FMT_W-1:0] code);
        return code > FMT_RGBA4;
    endfunction

endpackage

// File: rtl/scan_cfg_regs.sv
module scan_cfg_regs
    import scan_pkg::*;
#(
    parameter int NUM_SCREENS = 2,
    parameter int ADDR_W      = 32,
    parameter int SCR_W       = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SCR_W-1:0]          wr_screen,
    input  logic [REG_W-1:0]          wr_reg,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [DIM_W-1:0]          scr_width  [NUM_SCREENS],
    output logic [DIM_W-1:0]          scr_height [NUM_SCREENS],
    output logic [FMT_W-1:0]          scr_fmt    [NUM_SCREENS],
    output logic [ADDR_W-1:0]         scr_pitch  [NUM_SCREENS],
    output logic [NUM_BASES-1:0][ADDR_W-1:0] scr_base [NUM_SCREENS],
    output logic                      scr_bufsel [NUM_SCREENS]
);

    for (genvar s = 0; s < NUM_SCREENS; s++) begin : g_scr

        typedef struct packed {
            logic [DIM_W-1:0]                   width;
            logic [DIM_W-1:0]                   height;
            logic [FMT_W-1:0]                   fmt;
            logic [ADDR_W-1:0]                  pitch;
            logic [NUM_BASES-1:0][ADDR_W-1:0]   base;
            logic                               bufsel;
        } scr_regs_t;

        scr_regs_t regs_d, regs_q;
        logic      hit;

        assign hit = wr_en && (wr_screen == SCR_W'(s));

        always_comb begin
            regs_d = regs_q;
            if (hit) begin
                case (cfg_reg_e'(wr_reg))
                    REG_SIZE: begin
                        regs_d.width  = wr_data[DIM_W-1:0];
                        regs_d.height = wr_data[2*DIM_W-1:DIM_W];
                    end
                    REG_FMT:    regs_d.fmt     = wr_data[FMT_W-1:0];
                    REG_PITCH:  regs_d.pitch   = wr_data[ADDR_W-1:0];
                    REG_LEFT0:  regs_d.base[0] = wr_data[ADDR_W-1:0];
                    REG_LEFT1:  regs_d.base[1] = wr_data[ADDR_W-1:0];
                    REG_RIGHT0: regs_d.base[2] = wr_data[ADDR_W-1:0];
                    REG_RIGHT1: regs_d.base[3] = wr_data[ADDR_W-1:0];
                    REG_BUFSEL: regs_d.bufsel  = wr_data[0];
                    default:    regs_d = regs_q;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q <= '0;
            end else begin
                regs_q <= regs_d;
            end
        end

        assign scr_width[s]  = regs_q.width;
        assign scr_height[s] = regs_q.height;
        assign scr_fmt[s]    = regs_q.fmt;
        assign scr_pitch[s]  = regs_q.pitch;
        assign scr_base[s]   = regs_q.base;
        assign scr_bufsel[s] = regs_q.bufsel;
    end

endmodule

// File: rtl/scan_frame_select.sv
module scan_frame_select
    import scan_pkg::*;
#(
    parameter int NUM_SCREENS = 2,
    parameter int ADDR_W      = 32,
    parameter int SCR_W       = 1
) (
    input  logic [DIM_W-1:0]          scr_width  [NUM_SCREENS],
    input  logic [DIM_W-1:0]          scr_height [NUM_SCREENS],
    input  logic [FMT_W-1:0]          scr_fmt    [NUM_SCREENS],
    input  logic [ADDR_W-1:0]         scr_pitch  [NUM_SCREENS],
    input  logic [NUM_BASES-1:0][ADDR_W-1:0] scr_base [NUM_SCREENS],
    input  logic                      scr_bufsel [NUM_SCREENS],
    input  logic [SCR_W-1:0]          pick_screen,
    input  logic                      pick_right,
    output logic [DIM_W-1:0]          sel_width,
    output logic [DIM_W-1:0]          sel_height,
    output logic [ADDR_W-1:0]         sel_pitch,
    output logic [ADDR_W-1:0]         sel_base,
    output logic [BPP_W-1:0]          sel_bpp,
    output logic                      sel_bad
);

    logic [FMT_W-1:0] sel_fmt;
    logic [1:0]       base_idx;

    // Base index: bit 1 picks the eye, bit 0 picks the buffer set
    always_comb begin
        sel_width  = '0;
        sel_height = '0;
        sel_pitch  = '0;
        sel_base   = '0;
        sel_fmt    = '0;
        base_idx   = '0;
        for (int s = 0; s < NUM_SCREENS; s++) begin
            if (pick_screen == SCR_W'(s)) begin
                base_idx   = {pick_right, scr_bufsel[s]};
                sel_width  = scr_width[s];
                sel_height = scr_height[s];
                sel_pitch  = scr_pitch[s];
                sel_fmt    = scr_fmt[s];
                sel_base   = scr_base[s][base_idx];
            end
        end
    end

    assign sel_bpp = fmt_bpp(sel_fmt);
    assign sel_bad = fmt_bad(sel_fmt);

endmodule

// File: rtl/scan_raster_walker.sv
module scan_raster_walker
    import scan_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [ADDR_W-1:0] cfg_pitch,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [BPP_W-1:0]  cfg_bpp,
    input  logic              take,
    output logic              start_taken,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_last
);

    typedef struct packed {
        logic              active;
        logic [DIM_W-1:0]  col;
        logic [DIM_W-1:0]  row;
        logic [DIM_W-1:0]  width;
        logic [DIM_W-1:0]  height;
        logic [ADDR_W-1:0] pitch;
        logic [BPP_W-1:0]  bpp;
        logic [ADDR_W-1:0] row_base;
        logic [ADDR_W-1:0] addr;
    } walk_t;

    walk_t st_d, st_q;
    logic  col_end, row_end;

    assign col_end     = (st_q.col == st_q.width - DIM_W'(1));
    assign row_end     = (st_q.row == st_q.height - DIM_W'(1));
    assign start_taken = start && !st_q.active;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start_taken && (cfg_width != '0) && (cfg_height != '0)) begin
                st_d.active   = 1'b1;
                st_d.col      = '0;
                st_d.row      = '0;
                st_d.width    = cfg_width;
                st_d.height   = cfg_height;
                st_d.pitch    = cfg_pitch;
                st_d.bpp      = cfg_bpp;
                st_d.row_base = cfg_base;
                st_d.addr     = cfg_base;
            end
        end else if (take) begin
            if (col_end) begin
                st_d.col = '0;
                if (row_end) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.row      = st_q.row + DIM_W'(1);
                    st_d.row_base = st_q.row_base + st_q.pitch;
                    st_d.addr     = st_q.row_base + st_q.pitch;
                end
            end else begin
                st_d.col  = st_q.col + DIM_W'(1);
                st_d.addr = st_q.addr + ADDR_W'(st_q.bpp);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.active;
    assign out_addr  = st_q.addr;
    assign out_last  = st_q.active && col_end && row_end;

endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
    import scan_pkg::*;
#(
    parameter int NUM_SCREENS = 2,
    parameter int ADDR_W      = 32,
    localparam int SCR_W      = (NUM_SCREENS > 1) ? $clog2(NUM_SCREENS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SCR_W-1:0]  cfg_screen,
    input  logic [REG_W-1:0]  cfg_reg,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic [SCR_W-1:0]  frame_screen,
    input  logic              frame_right,
    input  logic              pix_ready,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_last,
    output logic              fmt_err
);

    logic [DIM_W-1:0]  scr_width  [NUM_SCREENS];
    logic [DIM_W-1:0]  scr_height [NUM_SCREENS];
    logic [FMT_W-1:0]  scr_fmt    [NUM_SCREENS];
    logic [ADDR_W-1:0] scr_pitch  [NUM_SCREENS];
    logic [NUM_BASES-1:0][ADDR_W-1:0] scr_base [NUM_SCREENS];
    logic              scr_bufsel [NUM_SCREENS];

    logic [DIM_W-1:0]  sel_width, sel_height;
    logic [ADDR_W-1:0] sel_pitch, sel_base;
    logic [BPP_W-1:0]  sel_bpp;
    logic              sel_bad;
    logic              start_taken;

    typedef struct packed {
        logic fmt_err;
    } top_state_t;

    top_state_t top_d, top_q;

    scan_cfg_regs #(
        .NUM_SCREENS (NUM_SCREENS),
        .ADDR_W      (ADDR_W),
        .SCR_W       (SCR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_screen  (cfg_screen),
        .wr_reg     (cfg_reg),
        .wr_data    (cfg_wdata),
        .scr_width  (scr_width),
        .scr_height (scr_height),
        .scr_fmt    (scr_fmt),
        .scr_pitch  (scr_pitch),
        .scr_base   (scr_base),
        .scr_bufsel (scr_bufsel)
    );

    scan_frame_select #(
        .NUM_SCREENS (NUM_SCREENS),
        .ADDR_W      (ADDR_W),
        .SCR_W       (SCR_W)
    ) u_select (
        .scr_width   (scr_width),
        .scr_height  (scr_height),
        .scr_fmt     (scr_fmt),
        .scr_pitch   (scr_pitch),
        .scr_base    (scr_base),
        .scr_bufsel  (scr_bufsel),
        .pick_screen (frame_screen),
        .pick_right  (frame_right),
        .sel_width   (sel_width),
        .sel_height  (sel_height),
        .sel_pitch   (sel_pitch),
        .sel_base    (sel_base),
        .sel_bpp     (sel_bpp),
        .sel_bad     (sel_bad)
    );

    scan_raster_walker #(
        .ADDR_W (ADDR_W)
    ) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (frame_start),
        .cfg_width   (sel_width),
        .cfg_height  (sel_height),
        .cfg_pitch   (sel_pitch),
        .cfg_base    (sel_base),
        .cfg_bpp     (sel_bpp),
        .take        (pix_ready),
        .start_taken (start_taken),
        .out_valid   (addr_valid),
        .out_addr    (addr),
        .out_last    (addr_last)
    );

    always_comb begin
        top_d = top_q;
        if (start_taken && sel_bad) begin
            top_d.fmt_err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign fmt_err = top_q.fmt_err;

endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              pix_ready,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] addr,
    input logic              addr_last,
    input logic              fmt_err
);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !pix_ready) |=> (addr_valid && $stable(addr)));

    assert_last_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid);

    assert_frame_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && pix_ready && addr_last) |=> !addr_valid);

    assert_walk_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !addr_last) |=> addr_valid);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmt_err) |-> $past(frame_start));

endmodule

bind scan_addr_gen scan_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pix_ready   (pix_ready),
    .addr_valid  (addr_valid),
    .addr        (addr),
    .addr_last   (addr_last),
    .fmt_err     (fmt_err)
);

// File: tb/scan_addr_gen_tb.sv
module scan_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [0:0]  cfg_screen;
    logic [2:0]  cfg_reg;
    logic [31:0] cfg_wdata;
    logic        frame_start;
    logic [0:0]  frame_screen;
    logic        frame_right;
    logic        pix_ready;
    logic        addr_valid;
    logic [31:0] addr;
    logic        addr_last;
    logic        fmt_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // Bench-side model of the setting registers
    int          m_w     [2];
    int          m_h     [2];
    int          m_fmt   [2];
    logic [31:0] m_pitch [2];
    logic [31:0] m_base  [2][4];
    int          m_sel   [2];

    always #2.5 clk = ~clk;

    scan_addr_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_screen   (cfg_screen),
        .cfg_reg      (cfg_reg),
        .cfg_wdata    (cfg_wdata),
        .frame_start  (frame_start),
        .frame_screen (frame_screen),
        .frame_right  (frame_right),
        .pix_ready    (pix_ready),
        .addr_valid   (addr_valid),
        .addr         (addr),
        .addr_last    (addr_last),
        .fmt_err      (fmt_err)
    );

    function automatic int exp_bpp(input int code);
        case (code)
            0: return 4;
            1: return 3;
            2, 3, 4: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [31:0] pitch,
                                             input int bpp, input int r, input int c);
        return base + pitch * 32'(r) + 32'(c) * 32'(bpp);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int scr, input int r, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_screen = scr[0]; cfg_reg = r[2:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (r)
            0: begin m_w[scr] = int'(d[15:0]); m_h[scr] = int'(d[31:16]); end
            1: m_fmt[scr] = int'(d[2:0]);
            2: m_pitch[scr] = d;
            3, 4, 5, 6: m_base[scr][r-3] = d;
            default: m_sel[scr] = int'(d[0]);
        endcase
    endtask

    task automatic setup(input int scr, input int w, input int h, input int fmt,
                         input logic [31:0] pitch, input int sel);
        wr(scr, 0, {16'(h), 16'(w)});
        wr(scr, 1, 32'(fmt));
        wr(scr, 2, pitch);
        wr(scr, 7, 32'(sel));
    endtask

    // Runs one frame and checks every address against the model
    task automatic run_frame(input int scr, input bit eye, input int rdy_pct,
                             input bit mid_wr, input bit busy_pulse, input bit same_wr,
                             input string tag);
        logic [31:0] base, pitch, new_val, prev_addr, e;
        int w, h, bpp, n, idx, cyc, bidx;
        bit stalled, rdy;
        w = m_w[scr]; h = m_h[scr]; bpp = exp_bpp(m_fmt[scr]); pitch = m_pitch[scr];
        bidx = (eye ? 2 : 0) + m_sel[scr];
        base = m_base[scr][bidx];
        n = w * h;
        new_val = $urandom;
        @(negedge clk);
        frame_start = 1'b1; frame_screen = scr[0]; frame_right = eye;
        if (same_wr) begin
            cfg_we = 1'b1; cfg_screen = scr[0]; cfg_reg = 3'(3 + bidx); cfg_wdata = new_val;
        end
        @(negedge clk);
        frame_start = 1'b0; cfg_we = 1'b0;
        if (same_wr) m_base[scr][bidx] = new_val;
        if (n == 0) begin
            for (int k = 0; k < 6; k++) begin
                chk(addr_valid == 1'b0, {"R9 empty frame ", tag}, 32'(addr_valid), 0);
                @(negedge clk);
            end
            return;
        end
        idx = 0; cyc = 0; stalled = 0; prev_addr = '0;
        while (idx < n && cyc < 4000) begin
            chk(addr_valid === 1'b1, {"R2 valid during frame ", tag}, 32'(addr_valid), 1);
            if (stalled) chk(addr === prev_addr, {"R7 hold on stall ", tag}, addr, prev_addr);
            rdy = (($urandom % 100) < rdy_pct);
            pix_ready = rdy;
            if (mid_wr && cyc == 0) begin
                cfg_we = 1'b1; cfg_screen = scr[0]; cfg_reg = 3'(3 + bidx); cfg_wdata = new_val;
                m_base[scr][bidx] = new_val;
            end else begin
                cfg_we = 1'b0;
            end
            frame_start = busy_pulse && (cyc == 1);
            if (rdy) begin
                e = exp_addr(base, pitch, bpp, idx / w, idx % w);
                chk(addr === e, {"R4 address ", tag}, addr, e);
                chk(addr_last === (idx == n - 1), {"R12 last flag ", tag},
                    32'(addr_last), 32'(idx == n - 1));
                idx++;
                stalled = 0;
            end else begin
                stalled = 1;
                prev_addr = addr;
            end
            @(negedge clk);
            cyc++;
        end
        pix_ready = 1'b0; cfg_we = 1'b0; frame_start = 1'b0;
        chk(idx == n, {"R2 pixel count ", tag}, 32'(idx), 32'(n));
        chk(addr_valid == 1'b0, {"R2 frame ends ", tag}, 32'(addr_valid), 0);
        repeat (3) @(negedge clk);
        chk(addr_valid == 1'b0, {"R8 no extra frame ", tag}, 32'(addr_valid), 0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_screen = '0; cfg_reg = '0; cfg_wdata = '0;
        frame_start = 1'b0; frame_screen = '0; frame_right = 1'b0; pix_ready = 1'b0;
        for (int s = 0; s < 2; s++) begin
            m_w[s] = 0; m_h[s] = 0; m_fmt[s] = 0; m_pitch[s] = '0; m_sel[s] = 0;
            for (int b = 0; b < 4; b++) m_base[s][b] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(addr_valid == 1'b0, "R1 reset valid", 32'(addr_valid), 0);
        chk(addr_last == 1'b0, "R1 reset last", 32'(addr_last), 0);
        chk(fmt_err == 1'b0, "R1 reset error", 32'(fmt_err), 0);
        // Registers are zero, so no addresses appear
        run_frame(0, 0, 100, 0, 0, 0, "R1 zero regs");
        run_frame(1, 1, 100, 0, 0, 0, "R1 zero regs");

        // Buffer set and eye selection
        for (int b = 0; b < 4; b++) wr(0, 3 + b, 32'h1000_0000 + 32'(b) * 32'h0100_0000);
        setup(0, 4, 3, 0, 32'd64, 0);
        run_frame(0, 0, 100, 0, 0, 0, "R5 set0 left");
        run_frame(0, 1, 100, 0, 0, 0, "R5 set0 right");
        wr(0, 7, 32'd1);
        run_frame(0, 0, 100, 0, 0, 0, "R5 set1 left");
        run_frame(0, 1, 100, 0, 0, 0, "R5 set1 right");

        // Second screen does not disturb the first
        for (int b = 0; b < 4; b++) wr(1, 3 + b, 32'h8000_0000 + 32'(b) * 32'h10);
        setup(1, 2, 5, 2, 32'd20, 1);
        run_frame(0, 1, 100, 0, 0, 0, "R11 screen0 after screen1 writes");
        run_frame(1, 0, 100, 0, 0, 0, "R11 screen1");

        // Byte steps per format
        for (int f = 0; f < 5; f++) begin
            wr(0, 1, 32'(f));
            run_frame(0, 0, 100, 0, 0, 0, "R3 format step");
        end

        // Writes overlapping a frame
        wr(0, 1, 32'd0);
        run_frame(0, 0, 100, 1, 0, 0, "R6 mid-frame write old base");
        run_frame(0, 0, 100, 0, 0, 0, "R6 next frame new base");
        run_frame(0, 1, 100, 0, 0, 1, "R6 same-cycle write old base");
        run_frame(0, 1, 100, 0, 0, 0, "R6 after same-cycle write");

        // Frame start while busy, and stalls
        run_frame(0, 0, 100, 0, 1, 0, "R8 start while busy");
        run_frame(0, 0, 30, 0, 0, 0, "R7 stalls");

        // Empty frames
        wr(0, 0, {16'd3, 16'd0});
        run_frame(0, 0, 100, 0, 0, 0, "R9 zero width");
        wr(0, 0, {16'd0, 16'd5});
        run_frame(0, 0, 100, 0, 0, 0, "R9 zero height");

        // Random frames with legal formats
        for (int i = 0; i < 24; i++) begin
            int s;
            s = int'($urandom % 2);
            for (int b = 0; b < 4; b++) wr(s, 3 + b, $urandom);
            setup(s, 1 + int'($urandom % 5), 1 + int'($urandom % 4), int'($urandom % 5),
                  $urandom % 256, int'($urandom % 2));
            run_frame(s, 1'($urandom % 2), 40 + int'($urandom % 61), 0, 0, 0, "R4 random");
        end
        chk(fmt_err == 1'b0, "R10 no error for legal codes", 32'(fmt_err), 0);

        // Illegal format codes
        setup(1, 3, 2, 5, 32'd100, 0);
        run_frame(1, 0, 100, 0, 0, 0, "R10 code 5");
        chk(fmt_err == 1'b1, "R10 error set", 32'(fmt_err), 1);
        wr(1, 1, 32'd7);
        run_frame(1, 1, 70, 0, 0, 0, "R10 code 7");
        wr(1, 1, 32'd0);
        run_frame(1, 0, 100, 0, 0, 0, "R10 legal after error");
        chk(fmt_err == 1'b1, "R10 error sticky", 32'(fmt_err), 1);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule